// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block sits on a two-wire serial bus as a slave and gives a bus host read and write access to a bank of 16-bit control registers that live outside it. The host addresses the block with a 7-bit device address whose top six bits are fixed by a parameter and whose lowest bit comes from an address-select pin. It then sends a 16-bit register pointer and either a run of 16-bit data words to write or, after a repeated start, reads data words back. Every word and the pointer travel high byte first. The pointer steps up by one after each word, so a burst touches consecutive registers.

On the register side the block presents a pointer, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data input that the register bank must return in the same cycle as the read strobe. One register, at a parameterised address, is held inside the block. It identifies the device and cannot be written. Both bus lines are resynchronised and deglitched before any start or stop decision is made. The block never stretches the clock and does not arbitrate against other masters.

Top module: `ctl_twi_slave`

## Requirements
- R1: SCL and SDA pass through a two-flop synchroniser and a filter that accepts a new level only after it has been stable for FILT_LEN system clocks (default 3). A one-cycle SDA pulse while SCL is high is neither a start nor a stop, and it does not corrupt the transfer in progress.
- R2: The block acknowledges the device-address byte only when its upper seven bits equal {DEV_ADDR_HI, addr_sel_i}, where bit 0 of that byte is the read/write flag (1 = read). On a mismatch it leaves SDA released for that byte and for every following byte up to the next start.
- R3: A write consists of the device address with flag 0, a pointer high byte, a pointer low byte and then data words, each sent as a high byte and then a low byte. Every byte is acknowledged. Each word gives one reg_wr_o pulse that carries the pointer and the word.
- R4: A word is committed only after both of its bytes have been received and acknowledged. A transfer that stops after a lone high byte produces no write strobe and leaves the register unchanged.
- R5: The pointer increments by one, wrapping modulo 2^16 and carrying from the low byte into the high byte, after every written word and after every fetched read word.
- R6: A read consists of a pointer write, a repeated start, the device address with flag 1, and data words. The first word comes from the pointer and each further word from the next register. Words are sent MSB first.
- R7: A host not-acknowledge on a low byte ends the read. SDA is released and no further read strobe is issued, so a read of N words gives N fetches.
- R8: At ID_ADDR the block returns {8'hA0, ID_REV} without a read strobe. A write to ID_ADDR produces no write strobe, but the pointer still advances.
- R9: reg_wr_o and reg_rd_o are each single-cycle pulses and are never high together.
- R10: sda_oe_o (1 = pull SDA low) changes only while SCL is low.
- R11: During and after reset, sda_oe_o, reg_wr_o and reg_rd_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Lowest bit of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr_o | output | 16 | Register pointer |
| reg_wdata_o | output | 16 | Word to be written |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 16 | Word at reg_addr_o, valid in the reg_rd_o cycle |
| reg_rd_o | output | 1 | One-cycle read strobe |

## Verification
A pad edge reaches the engine about six system clocks later: two synchroniser flops, three filter counts and one edge-detect register. A read word fetched after a falling SCL edge appears on SDA one clock after that. The bench drives each bus line change a quarter bit period (10 clocks) after the previous one and samples acknowledge and data bits in the middle of the SCL high phase, so every result is already settled when it is read. Write and read strobes are counted at negative clock edges and compared only after the stop plus five idle clocks, when every strobe of the transfer has happened.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] ID_UPPER = 8'hA0;

   typedef enum logic [2:0] {
      PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_WHI, PH_WLO, PH_RHI, PH_RLO
   } phase_t;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_o <= 1'b1;
            else        line_o <= synced;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_LEN);
         localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               line_o <= 1'b1;
            end else if (synced == line_o) begin
               cnt <= '0;
            end else if (cnt == LIMIT) begin
               cnt    <= '0;
               line_o <= synced;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import twi_slave_pkg::*;
#(
   parameter logic [5:0] DEV_ADDR_HI = 6'h15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic              addr_sel_i,
   input  logic [WORD_W-1:0] fetch_data_i,
   output logic              sda_oe_o,
   output logic [WORD_W-1:0] ptr_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              wr_evt_o,
   output logic              rd_evt_o
);
   phase_t            phase;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg, wd_hi, txbyte;
   logic [WORD_W-1:0] word;
   logic              scl_q, sda_q, rw_q, mack_q, tx;
   logic              scl_rise, scl_fall, start_c, stop_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_c  = scl & scl_q & sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q & sda;
   assign tx       = (phase == PH_RHI) || (phase == PH_RLO);
   assign txbyte   = (phase == PH_RHI) ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         wd_hi    <= '0;
         word     <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         sda_oe_o <= 1'b0;
         ptr_o    <= '0;
         wdata_o  <= '0;
         wr_evt_o <= 1'b0;
         rd_evt_o <= 1'b0;
      end else begin
         wr_evt_o <= 1'b0;
         rd_evt_o <= 1'b0;
         if (wr_evt_o) ptr_o <= ptr_o + 1'b1;
         if (rd_evt_o) begin
            word     <= fetch_data_i;
            ptr_o    <= ptr_o + 1'b1;
            sda_oe_o <= ~fetch_data_i[WORD_W-1];
         end
         if (start_c) begin
            phase    <= PH_DEV;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_c) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise && bitcnt < 4'd9) begin
               if (!tx && bitcnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda};
               if (tx && bitcnt == 4'd8) mack_q <= ~sda;
               bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
               case (bitcnt)
                  4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
                     if (tx) sda_oe_o <= ~txbyte[3'd7 - bitcnt[2:0]];
                  end
                  4'd8: begin
                     if (tx) sda_oe_o <= 1'b0;
                     else begin
                        case (phase)
                           PH_DEV: begin
                              if (shreg[7:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                                 sda_oe_o <= 1'b1;
                                 rw_q     <= shreg[0];
                              end else begin
                                 phase <= PH_IDLE;
                              end
                           end
                           PH_AHI: begin ptr_o[WORD_W-1:BYTE_W] <= shreg; sda_oe_o <= 1'b1; end
                           PH_ALO: begin ptr_o[BYTE_W-1:0] <= shreg;      sda_oe_o <= 1'b1; end
                           PH_WHI: begin wd_hi <= shreg;                  sda_oe_o <= 1'b1; end
                           PH_WLO: begin wdata_o <= {wd_hi, shreg};       sda_oe_o <= 1'b1; end
                           default: ;
                        endcase
                     end
                  end
                  4'd9: begin
                     bitcnt   <= '0;
                     sda_oe_o <= 1'b0;
                     case (phase)
                        PH_DEV: begin
                           phase    <= rw_q ? PH_RHI : PH_AHI;
                           rd_evt_o <= rw_q;
                        end
                        PH_AHI: phase <= PH_ALO;
                        PH_ALO: phase <= PH_WHI;
                        PH_WHI: phase <= PH_WLO;
                        PH_WLO: begin
                           phase    <= PH_WHI;
                           wr_evt_o <= 1'b1;
                        end
                        PH_RHI: begin
                           if (mack_q) begin
                              phase    <= PH_RLO;
                              sda_oe_o <= ~word[BYTE_W-1];
                           end else phase <= PH_IDLE;
                        end
                        PH_RLO: begin
                           if (mack_q) begin
                              phase    <= PH_RHI;
                              rd_evt_o <= 1'b1;
                           end else phase <= PH_IDLE;
                        end
                        default: ;
                     endcase
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/ctl_twi_slave.sv
module ctl_twi_slave
   import twi_slave_pkg::*;
#(
   parameter logic [5:0]        DEV_ADDR_HI = 6'h15,
   parameter logic [WORD_W-1:0] ID_ADDR     = 16'h0000,
   parameter logic [BYTE_W-1:0] ID_REV      = 8'h11,
   parameter int                SYNC_STAGES = 2,
   parameter int                FILT_LEN    = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   input  logic        addr_sel_i,
   output logic        sda_oe_o,
   output logic [15:0] reg_addr_o,
   output logic [15:0] reg_wdata_o,
   output logic        reg_wr_o,
   input  logic [15:0] reg_rdata_i,
   output logic        reg_rd_o
);
   localparam int NLINES = 2;
   localparam logic [WORD_W-1:0] ID_WORD = {ID_UPPER, ID_REV};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [NLINES-1:0] raw, clean;
   logic              scl_clean, sda_clean;
   logic              wr_evt, rd_evt, id_hit;
   logic [WORD_W-1:0] fetch_data;

   assign raw = {sda_i, scl_i};

   for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
      twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
         .clk(clk), .rst_n(rst_n), .line_i(raw[gi]), .line_o(clean[gi]));
   end

   assign scl_clean = clean[0];
   assign sda_clean = clean[1];

   twi_slave_fsm #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl(scl_clean), .sda(sda_clean),
      .addr_sel_i(addr_sel_i), .fetch_data_i(fetch_data), .sda_oe_o(sda_oe_o),
      .ptr_o(reg_addr_o), .wdata_o(reg_wdata_o), .wr_evt_o(wr_evt), .rd_evt_o(rd_evt));

   assign id_hit     = (reg_addr_o == ID_ADDR);
   assign fetch_data = id_hit ? ID_WORD : reg_rdata_i;
   assign reg_wr_o   = wr_evt & ~id_hit;
   assign reg_rd_o   = rd_evt & ~id_hit;
endmodule

// File: rtl/twi_slave_checker.sv
module twi_slave_checker #(
   parameter logic [15:0] ID_ADDR = 16'h0000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_clean,
   input logic        sda_oe_o,
   input logic        reg_wr_o,
   input logic        reg_rd_o,
   input logic [15:0] reg_addr_o
);
   assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o);
   assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> !reg_rd_o);
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_o && reg_rd_o));
   assert_id_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> reg_addr_o != ID_ADDR);
   assert_wr_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> reg_addr_o == 16'($past(reg_addr_o) + 16'd1));
   assert_rd_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> reg_addr_o == 16'($past(reg_addr_o) + 16'd1));
   assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_clean);
endmodule

bind ctl_twi_slave twi_slave_checker #(.ID_ADDR(ID_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_clean(scl_clean), .sda_oe_o(sda_oe_o),
   .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o));

// File: tb/ctl_twi_slave_bench.sv
module ctl_twi_slave_bench;
   localparam logic [5:0]  DEV_HI = 6'h15;
   localparam logic [15:0] ID_A   = 16'h0000;
   localparam logic [7:0]  REV    = 8'h3C;
   localparam int          Q      = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_scl = 1'b1, host_sda = 1'b1, sel = 1'b1;
   logic        sda_line, sda_oe_o, reg_wr_o, reg_rd_o;
   logic [15:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
   logic [15:0] bmem [0:255];
   logic [15:0] exp_mem [0:255];
   logic [15:0] wbuf [0:3];
   int          checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, viol = 0;
   logic        glitch = 1'b0, prev_oe = 1'b0;

   always #4 clk = ~clk;

   assign sda_line    = host_sda & ~sda_oe_o;
   assign reg_rdata_i = bmem[reg_addr_o[7:0]];

   ctl_twi_slave #(.DEV_ADDR_HI(DEV_HI), .ID_ADDR(ID_A), .ID_REV(REV),
                   .SYNC_STAGES(2), .FILT_LEN(3)) u_ctl_twi_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
      .addr_sel_i(sel), .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o),
      .reg_wdata_o(reg_wdata_o), .reg_wr_o(reg_wr_o), .reg_rdata_i(reg_rdata_i),
      .reg_rd_o(reg_rd_o));

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr_o) begin bmem[reg_addr_o[7:0]] = reg_wdata_o; wr_cnt++; end
         if (reg_rd_o) rd_cnt++;
         if (sda_oe_o != prev_oe && host_scl) viol++;
      end
      prev_oe = sda_oe_o;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] dev_byte(input logic rw);
      return {DEV_HI, sel, rw};
   endfunction

   function automatic logic [15:0] exp_read(input logic [15:0] a);
      return (a == ID_A) ? {8'hA0, REV} : exp_mem[a[7:0]];
   endfunction

   task automatic q; repeat (Q) @(negedge clk); endtask

   task automatic bus_start;
      host_sda = 1'b1; q; host_scl = 1'b1; q; host_sda = 1'b0; q; host_scl = 1'b0; q;
   endtask

   task automatic bus_stop;
      host_sda = 1'b0; q; host_scl = 1'b1; q; host_sda = 1'b1; q;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         host_sda = b[i]; q; host_scl = 1'b1; q;
         if (glitch && b[i]) begin
            host_sda = 1'b0; @(negedge clk); host_sda = 1'b1; glitch = 1'b0;
         end
         q; host_scl = 1'b0; q;
      end
      host_sda = 1'b1; q; host_scl = 1'b1; q; ack = ~sda_line; q; host_scl = 1'b0; q;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q; host_scl = 1'b1; q; b[i] = sda_line; q; host_scl = 1'b0;
      end
      q; host_sda = ~give_ack; q; host_scl = 1'b1; q; q; host_scl = 1'b0; q; host_sda = 1'b1;
   endtask

   task automatic send_ptr(input logic [15:0] a);
      logic ack;
      bus_start; send_byte(dev_byte(1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
      send_byte(a[15:8], ack); chk(ack, "R3 ptr hi ack", ack, 1);
      send_byte(a[7:0], ack);  chk(ack, "R3 ptr lo ack", ack, 1);
   endtask

   task automatic do_write(input logic [15:0] a, input int n);
      logic ack; int w0, expw;
      w0 = wr_cnt; expw = 0;
      send_ptr(a);
      for (int k = 0; k < n; k++) begin
         logic [15:0] ad;
         ad = 16'(a + 16'(k));
         send_byte(wbuf[k][15:8], ack); chk(ack, "R3 data hi ack", ack, 1);
         send_byte(wbuf[k][7:0], ack);  chk(ack, "R3 data lo ack", ack, 1);
         if (ad != ID_A) begin exp_mem[ad[7:0]] = wbuf[k]; expw++; end
      end
      bus_stop; repeat (5) @(negedge clk);
      chk(wr_cnt - w0 == expw, "R3 R8 write strobes", wr_cnt - w0, expw);
   endtask

   task automatic do_read(input logic [15:0] a, input int n);
      logic ack; logic [7:0] hi, lo; int r0, expr;
      r0 = rd_cnt; expr = 0;
      send_ptr(a);
      bus_start; send_byte(dev_byte(1'b1), ack); chk(ack, "R6 read dev ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         logic [15:0] ad;
         ad = 16'(a + 16'(k));
         recv_byte(1'b1, hi); recv_byte(k < n - 1, lo);
         chk({hi, lo} == exp_read(ad), "R6 R5 read word", {hi, lo}, exp_read(ad));
         if (ad != ID_A) expr++;
      end
      bus_stop; repeat (5) @(negedge clk);
      chk(rd_cnt - r0 == expr, "R7 read strobes", rd_cnt - r0, expr);
      chk(sda_oe_o == 1'b0, "R7 released", sda_oe_o, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic ack; int w0;
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 16'(16'hC000 ^ (i * 16'h0101));
         exp_mem[i] = bmem[i];
      end
      repeat (5) @(negedge clk);
      chk(sda_oe_o == 1'b0, "R11 sda", sda_oe_o, 0);
      chk(reg_wr_o == 1'b0, "R11 wr", reg_wr_o, 0);
      chk(reg_rd_o == 1'b0, "R11 rd", reg_rd_o, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe_o == 1'b0, "R11 after release", sda_oe_o, 0);

      // basic write and read back
      wbuf[0] = 16'h1234; wbuf[1] = 16'hABCD;
      do_write(16'h0010, 2); do_read(16'h0010, 2);

      // identification register
      wbuf[0] = 16'hFFFF; wbuf[1] = 16'h5A5A;
      do_write(ID_A, 2); do_read(ID_A, 2);

      // wrong device address
      w0 = wr_cnt;
      bus_start; send_byte({DEV_HI, ~sel, 1'b0}, ack); chk(!ack, "R2 mismatch nack", ack, 0);
      send_byte(8'h00, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
      bus_stop; repeat (5) @(negedge clk);
      chk(wr_cnt == w0, "R2 no strobe", wr_cnt - w0, 0);
      sel = 1'b0;
      wbuf[0] = 16'h0F0F; do_write(16'h0033, 1); do_read(16'h0033, 1);
      sel = 1'b1;

      // lone high byte
      w0 = wr_cnt;
      send_ptr(16'h0020); send_byte(8'h99, ack); chk(ack, "R4 hi ack", ack, 1);
      bus_stop; repeat (5) @(negedge clk);
      chk(wr_cnt == w0, "R4 no commit", wr_cnt - w0, 0);
      do_read(16'h0020, 1);

      // pointer carry into the high byte
      wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
      do_write(16'h00FE, 3); do_read(16'h00FE, 3);

      // one-cycle glitch on SDA while SCL high
      glitch = 1'b1; wbuf[0] = 16'h00FF;
      do_write(16'h0040, 1);
      chk(glitch == 1'b0, "R1 glitch applied", glitch, 0);
      do_read(16'h0040, 1);

      // random transfers
      for (int it = 0; it < 8; it++) begin
         logic [15:0] a; int n;
         a = 16'($urandom_range(0, 255));
         n = $urandom_range(1, 3);
         for (int k = 0; k < n; k++) wbuf[k] = 16'($urandom);
         do_write(a, n);
         do_read(a, $urandom_range(1, 3));
      end

      chk(viol == 0, "R10 SDA moves only with SCL low", viol, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule